// File: doc/BRIEF.md
# Streaming Impulse-Noise Filter

This block cleans salt-and-pepper noise from an 8-bit greyscale image that arrives one pixel at a time in raster order. A pixel counts as noise only when it sits at one of the two fixed impulse levels, the darkest code or the brightest code. Clean pixels leave the block untouched. A noisy pixel is replaced by a value taken from its 3x3 neighbourhood. If the neighbourhood is too badly damaged, the block repeats the pixel it sent out just before.

Two line delays and a 3x3 register window give each pixel its neighbours. Each result leaves the block one line plus two steps after its own pixel. The bottom row would need a row that never arrives, so after the final end-of-line marker the block steps itself through one more line and one more pixel. This makes the last row come out without any extra input.

Top module: `impulse_filter`

## Requirements
- R1: A pixel is treated as corrupted exactly when its value is 0 or 255. Every other value counts as clean.
- R2: When the centre pixel is clean, the output equals the centre pixel.
- R3: When the centre is corrupted and the window holds at most BAD_LIMIT (default 8) corrupted values, the output is the lower median of the window's clean values. The lower median is the element at index floor((n-1)/2) of the n clean values sorted in ascending order.
- R4: When the centre is corrupted and the window holds more than BAD_LIMIT corrupted values, or all nine are corrupted, the output repeats the previous output pixel.
- R5: At the frame edges, missing neighbours are filled from the image itself. A row above row 0 or below row IMG_H-1 is replaced by the centre row. A column left of column 0 or right of column IMG_W-1 is replaced by the centre column.
- R6: Pixel index j (row*IMG_W+col) is output with out_valid high. This happens on the clock edge that follows the edge accepting input step j+IMG_W+1.
- R7: The step in R6 is either an input pixel or a self-generated flush step. After the frame's final end-of-line, the block runs IMG_W+1 flush steps on consecutive cycles. All inputs are ignored during the flush.
- R8: A start-of-frame pixel sets the previous-output value to 128.
- R9: After reset, out_valid is 0 and out_pix is 0.
- R10: Each frame yields exactly IMG_W*IMG_H outputs, in raster order.
- R11: A frame opens on an accepted pixel with in_sof high. Each row is exactly IMG_W pixels and closes with in_eol high. The end-of-line of row IMG_H-1 closes the frame. A valid pixel without in_sof while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel strobe |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_eol | input | 1 | Marks the last pixel of a row |
| in_pix | input | PW | Input pixel value |
| out_valid | output | 1 | Output pixel strobe |
| out_pix | output | PW | Filtered pixel value |

## Verification
The bench sends frames with gaps between pixels and compares every output against a behavioural model, both on its value and on the exact cycle it appears. It targets four weak spots:
- Corner and edge pixels: a design that replicates the edges wrongly produces wrong values along the borders.
- Fully corrupted neighbourhoods: one of these sits in a frame corner. A design that does not reset the previous output to 128 at start-of-frame, or that takes the median of nothing, outputs the wrong value there.
- The bottom row: this row exists only because of the flush. A missing or short flush loses it, and an uncounted flush shifts the output timing.
- Stray inputs: start-of-frame pixels sent during the flush and valid pixels sent while idle must do nothing. If either started a frame, garbage outputs or restarted counters would appear.

// File: rtl/ifl_pkg.sv
package ifl_pkg;

    // Frame sequencing: waiting, taking pixels, self-stepping the last line
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_FLUSH = 2'd2
    } phase_e;

endpackage

// File: rtl/ifl_linebuf.sv
// One line of delay: reads the old word at addr, then overwrites it.
module ifl_linebuf #(
    parameter int DEPTH = 512,
    parameter int PW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] dout
);

    logic [PW-1:0] mem [DEPTH];

    assign dout = mem[addr];

    always_ff @(posedge clk) begin
        if (en) begin
            mem[addr] <= din;
        end
    end

endmodule

// File: rtl/ifl_restore.sv
// Counts impulse values in a 9-value window and picks the lower median
// of the clean ones by ranking each clean value against the others.
module ifl_restore #(
    parameter int PW = 8
) (
    input  logic [8:0][PW-1:0] win,
    output logic [3:0]         n_bad,
    output logic [PW-1:0]      med
);

    localparam logic [PW-1:0] LVL_LO = '0;
    localparam logic [PW-1:0] LVL_HI = '1;

    logic [8:0]      clean;
    logic [8:0][3:0] rank;
    logic [3:0]      target;

    for (genvar i = 0; i < 9; i++) begin : g_det
        assign clean[i] = (win[i] != LVL_LO) && (win[i] != LVL_HI);
    end

    always_comb begin
        n_bad = 4'd9;
        for (int i = 0; i < 9; i++) begin
            n_bad = n_bad - {3'd0, clean[i]};
        end
        target = (4'd8 - n_bad) >> 1;
    end

    for (genvar i = 0; i < 9; i++) begin : g_rank
        always_comb begin
            rank[i] = 4'd0;
            for (int j = 0; j < 9; j++) begin
                if (clean[j] && ((win[j] < win[i]) || ((win[j] == win[i]) && (j < i)))) begin
                    rank[i] = rank[i] + 4'd1;
                end
            end
        end
    end

    always_comb begin
        med = '0;
        for (int i = 0; i < 9; i++) begin
            if (clean[i] && (rank[i] == target)) begin
                med = med | win[i];
            end
        end
    end

endmodule

// File: rtl/impulse_filter.sv
module impulse_filter
    import ifl_pkg::*;
#(
    parameter int PW        = 8,
    parameter int IMG_W     = 512,
    parameter int IMG_H     = 512,
    parameter int BAD_LIMIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eol,
    input  logic [PW-1:0] in_pix,
    output logic          out_valid,
    output logic [PW-1:0] out_pix
);

    localparam int COL_W = $clog2(IMG_W);
    localparam int ROW_W = $clog2(IMG_H);
    localparam int LAG_W = $clog2(IMG_W + 2);
    localparam int FL_W  = $clog2(IMG_W + 1);

    localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 1);
    localparam logic [LAG_W-1:0] LAG_FULL = LAG_W'(IMG_W + 1);
    localparam logic [FL_W-1:0]  FL_LAST  = FL_W'(IMG_W);
    localparam logic [PW-1:0]    LVL_LO   = '0;
    localparam logic [PW-1:0]    LVL_HI   = '1;
    localparam logic [PW-1:0]    LVL_MID  = PW'(1 << (PW - 1));

    typedef logic [2:0][PW-1:0] col_t;   // [0] top, [1] middle, [2] newest row

    typedef struct packed {
        phase_e           ph;
        logic [ROW_W-1:0] irow;
        logic [FL_W-1:0]  fcnt;
        logic [COL_W-1:0] wp;
        logic [LAG_W-1:0] lag;
        logic [COL_W-1:0] ncol;
        logic [ROW_W-1:0] nrow;
        logic [2:0][2:0][PW-1:0] win;    // [column: 0 oldest .. 2 newest][row]
        logic             win_vld;
        logic [COL_W-1:0] wcol;
        logic [ROW_W-1:0] wrow;
        logic [PW-1:0]    prev;
        logic             ovld;
        logic [PW-1:0]    opix;
    } state_t;

    state_t q, d;

    logic             start, take, ftick, tick;
    logic [PW-1:0]    pix_in;
    logic [COL_W-1:0] wr_addr;
    logic [LAG_W-1:0] base_lag;
    logic [ROW_W-1:0] base_row;
    logic [PW-1:0]    lb_in  [2];
    logic [PW-1:0]    lb_out [2];
    col_t             col_in;
    logic [8:0][PW-1:0] eff;
    logic [3:0]       n_bad;
    logic [PW-1:0]    med;
    logic [PW-1:0]    centre_pix;
    logic             centre_bad;
    logic [PW-1:0]    result;

    // Two chained line delays supply the rows above the incoming one
    always_comb begin
        lb_in[0] = pix_in;
        lb_in[1] = lb_out[0];
    end

    for (genvar g = 0; g < 2; g++) begin : g_line
        ifl_linebuf #(
            .DEPTH (IMG_W),
            .PW    (PW)
        ) u_lb (
            .clk  (clk),
            .en   (tick),
            .addr (wr_addr),
            .din  (lb_in[g]),
            .dout (lb_out[g])
        );
    end

    assign col_in = {pix_in, lb_out[0], lb_out[1]};

    // Edge replication: out-of-frame rows/columns fall back to the centre one
    always_comb begin
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                int rs, cs;
                rs = r;
                cs = c;
                if (r == 0 && q.wrow == '0)      rs = 1;
                if (r == 2 && q.wrow == ROW_LAST) rs = 1;
                if (c == 0 && q.wcol == '0)      cs = 1;
                if (c == 2 && q.wcol == COL_LAST) cs = 1;
                eff[r*3+c] = q.win[cs][rs];
            end
        end
    end

    ifl_restore #(
        .PW (PW)
    ) u_restore (
        .win   (eff),
        .n_bad (n_bad),
        .med   (med)
    );

    assign centre_pix = q.win[1][1];
    assign centre_bad = (centre_pix == LVL_LO) || (centre_pix == LVL_HI);

    always_comb begin
        if (!centre_bad) begin
            result = centre_pix;
        end else if ((int'(n_bad) > BAD_LIMIT) || (n_bad == 4'd9)) begin
            result = q.prev;
        end else begin
            result = med;
        end
    end

    always_comb begin
        d        = q;
        start    = in_valid && in_sof && (q.ph != PH_FLUSH);
        take     = start || ((q.ph == PH_RUN) && in_valid);
        ftick    = (q.ph == PH_FLUSH);
        tick     = take || ftick;
        pix_in   = ftick ? '0 : in_pix;
        wr_addr  = start ? '0 : q.wp;
        base_lag = start ? '0 : q.lag;
        base_row = start ? '0 : q.irow;
        d.win_vld = 1'b0;

        if (start) begin
            d.ph   = PH_RUN;
            d.irow = '0;
            d.ncol = '0;
            d.nrow = '0;
        end

        if (tick) begin
            d.wp  = (wr_addr == COL_LAST) ? '0 : wr_addr + 1'b1;
            d.win = {col_in, q.win[2], q.win[1]};
            if (base_lag == LAG_FULL) begin
                d.win_vld = 1'b1;
                d.wcol    = q.ncol;
                d.wrow    = q.nrow;
                if (q.ncol == COL_LAST) begin
                    d.ncol = '0;
                    d.nrow = q.nrow + 1'b1;
                end else begin
                    d.ncol = q.ncol + 1'b1;
                end
            end else begin
                d.lag = base_lag + 1'b1;
            end
        end

        if (take && in_eol) begin
            if (base_row == ROW_LAST) begin
                d.ph   = PH_FLUSH;
                d.fcnt = '0;
            end else begin
                d.irow = base_row + 1'b1;
            end
        end

        if (ftick) begin
            if (q.fcnt == FL_LAST) d.ph = PH_IDLE;
            else                   d.fcnt = q.fcnt + 1'b1;
        end

        d.ovld = q.win_vld;
        if (q.win_vld) begin
            d.opix = result;
            d.prev = result;
        end
        if (start) d.prev = LVL_MID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= PH_IDLE;
            q.prev <= LVL_MID;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.ovld;
    assign out_pix   = q.opix;

    a_r2_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (q.win_vld && !centre_bad) |=> (q.opix == $past(centre_pix)));

    a_r3_median_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (q.win_vld && centre_bad && (int'(n_bad) <= BAD_LIMIT) && (n_bad != 4'd9))
        |=> ((q.opix != LVL_LO) && (q.opix != LVL_HI)));

    a_r4_prev_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (q.win_vld && centre_bad && (n_bad == 4'd9)) |=> (q.opix == $past(q.prev)));

    a_r6_valid_follows_window: assert property (@(posedge clk) disable iff (!rst_n)
        q.win_vld |=> q.ovld);

    a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !q.win_vld |=> !q.ovld);

    a_r7_flush_steps_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_FLUSH) |=> q.win_vld);

    a_r8_prev_mid_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.prev == LVL_MID));

endmodule

// File: tb/impulse_filter_tb_top.sv
module impulse_filter_tb_top;

    localparam int W    = 8;
    localparam int H    = 6;
    localparam int NPIX = W * H;
    localparam int LIM  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_eol = 1'b0;
    logic [7:0] in_pix = 8'd0;
    logic       out_valid;
    logic [7:0] out_pix;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int nj = 0;
    bit done = 1'b0;

    int    fr [H][W];
    int    exp_val [NPIX];
    int    exp_cyc [NPIX];
    string exp_tag [NPIX];

    always #2.5 clk = ~clk;

    impulse_filter #(
        .PW        (8),
        .IMG_W     (W),
        .IMG_H     (H),
        .BAD_LIMIT (LIM)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eol    (in_eol),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit is_imp(input int v);
        return (v == 0) || (v == 255);
    endfunction

    // Behavioural reference over a whole frame, raster order
    function automatic void build_ref();
        int prev;
        prev = 128;
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                int j, o, nbad, n;
                int vals [9];
                string tag;
                j = r * W + c;
                if (!is_imp(fr[r][c])) begin
                    o = fr[r][c];
                    tag = "R1 R2";
                end else begin
                    nbad = 0;
                    n = 0;
                    for (int dr = -1; dr <= 1; dr++) begin
                        for (int dc = -1; dc <= 1; dc++) begin
                            int rr, cc, v;
                            rr = (r + dr < 0) ? 0 : ((r + dr > H - 1) ? H - 1 : r + dr);
                            cc = (c + dc < 0) ? 0 : ((c + dc > W - 1) ? W - 1 : c + dc);
                            v = fr[rr][cc];
                            if (is_imp(v)) nbad++;
                            else begin
                                int p;
                                p = n;
                                while (p > 0 && vals[p-1] > v) begin
                                    vals[p] = vals[p-1];
                                    p--;
                                end
                                vals[p] = v;
                                n++;
                            end
                        end
                    end
                    if (nbad > LIM || nbad == 9) begin
                        o = prev;
                        tag = (j == 0) ? "R4 R8" : "R4";
                    end else begin
                        o = vals[(n - 1) / 2];
                        tag = "R3";
                    end
                    if (r == 0 || c == 0 || r == H - 1 || c == W - 1) tag = {tag, " R5"};
                end
                if (r == H - 1) tag = {tag, " R7"};
                exp_val[j] = o;
                exp_tag[j] = tag;
                prev = o;
            end
        end
    endfunction

    // Value/timing monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (nj >= NPIX) begin
                    chk(1'b0, "R11 R10 unexpected output", int'(out_pix), -1);
                end else begin
                    chk(cyc == exp_cyc[nj], "R6 output cycle", cyc, exp_cyc[nj]);
                    chk(int'(out_pix) == exp_val[nj], exp_tag[nj], int'(out_pix), exp_val[nj]);
                    nj++;
                end
            end else if (nj < NPIX && exp_cyc[nj] == cyc) begin
                chk(1'b0, "R6 missing output", 0, 1);
                nj++;
            end
        end
    end

    task automatic run_frame(input int seed, input int heavy, input bit junk_in_flush);
        int tcyc;
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                bit noisy;
                fr[r][c] = 1 + (r * 37 + c * 11 + seed * 53) % 254;
                if (heavy != 0) noisy = ((r * 3 + c + seed) % 3) != 0;
                else            noisy = ((r * 5 + c * 3 + seed) % 7) == 0;
                if (heavy != 0 && r < 2 && c < 2) noisy = 1'b1;
                if (heavy != 0 && r >= 2 && r <= 4 && c >= 3 && c <= 5) noisy = 1'b1;
                if (noisy) fr[r][c] = ((r + c) % 2 != 0) ? 255 : 0;
            end
        end
        build_ref();
        for (int j = 0; j < NPIX; j++) exp_cyc[j] = 1 << 30;
        nj = 0;
        tcyc = 0;
        for (int k = 0; k < NPIX; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (k == 0);
            in_eol   = ((k % W) == W - 1);
            in_pix   = 8'(fr[k / W][k % W]);
            tcyc     = cyc + 1;
            if (k >= W + 1) exp_cyc[k - W - 1] = tcyc + 1;
            if (((k + seed) % 4) == 3) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sof   = 1'b0;
                in_eol   = 1'b0;
            end
        end
        for (int f = 0; f <= W; f++) exp_cyc[NPIX + f - W - 1] = tcyc + 2 + f;
        @(negedge clk);
        if (junk_in_flush) begin
            for (int i = 0; i < W; i++) begin
                in_valid = 1'b1;
                in_sof   = 1'b1;
                in_eol   = 1'b1;
                in_pix   = 8'd77;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eol   = 1'b0;
        repeat (W + 6) @(negedge clk);
        chk(nj == NPIX, "R10 R7 output count", nj, NPIX);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R9 reset valid", int'(out_valid), 0);
        chk(out_pix == 8'd0, "R9 reset pixel", int'(out_pix), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 idle after reset", int'(out_valid), 0);

        run_frame(1, 0, 1'b0);
        run_frame(2, 1, 1'b1);

        // R11: valid pixels without start-of-frame while idle do nothing
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_eol   = (i == 4);
            in_pix   = 8'(i * 40);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_eol   = 1'b0;
        repeat (W + 6) @(negedge clk);
        chk(nj == NPIX, "R11 stray input ignored", nj, NPIX);

        run_frame(5, 1, 1'b0);
        run_frame(3, 0, 1'b1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule